// File: doc/BRIEF.md
# Round-Robin Shared-Bus Arbiter with Split Masking

This block decides which of a small group of bus masters owns a shared AHB-style segment. Every master has a request line that may rise or fall in any cycle. When the transfer on the bus finishes (`ready` high), the arbiter looks at all requests and hands the bus to the requester that comes next in a rotating order. A master that has just won moves behind every other waiting requester. When no master is eligible, ownership parks on a fixed default master.

A split-capable target may answer the owner's transfer with a split response. That master is then shut out of arbitration, and the other masters keep sharing the bus. Later the target raises that master's bit on a per-master completion vector. The master becomes eligible again and waits for its normal turn in the rotation. It gets no priority boost. The block also produces single-cycle event strobes for an external performance counter: an ownership change, a split being taken, and a split being released.

Top module: `rr_split_arbiter`

## Requirements
- R1: While reset is asserted, and afterwards until the first arbitration, master DEFAULT_MASTER (index 0 by default) owns the bus and all split masks are clear. The first arbitration after reset searches from master 0 upward.
- R2: Exactly one bit of `grant` is high in every cycle. Bit i of `grant` is high exactly when `owner` equals i.
- R3: Ownership changes only at a clock edge where `ready` is high. The new owner appears in the cycle after that edge and holds while `ready` is low.
- R4: At each arbitration the winner is the first eligible requester found by searching upward, with wrap-around, from the index one above the previous arbitration winner. With all four masters requesting continuously, the owners are 0, 1, 2, 3, 0, and so on.
- R5: At an arbitration with no eligible requester, the owner becomes DEFAULT_MASTER. The search start point is left unchanged.
- R6: A split response (`split_resp` high in a cycle with `ready` high) masks the current owner. A masked master is not eligible, so the next owner is chosen from the remaining requesters in the same arbitration.
- R7: A high bit i of `split_done` clears the mask of master i. That master can win in the same arbitration, but only when the rotation reaches it.
- R8: When a split response for master i and `split_done[i]` occur in the same cycle, master i's mask ends up clear.
- R9: `ev_grant_change` pulses for one cycle after an arbitration that changed the owner. `ev_split_start` pulses after a split response is taken. `ev_split_done` pulses after a `split_done` bit releases a mask that was set or was being set in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | N_MASTERS | Per-master bus request |
| ready | input | 1 | Current transfer completes this cycle; arbitration point |
| split_resp | input | 1 | Target gives a split response to the current owner |
| split_done | input | N_MASTERS | Per-master split completion from the target |
| grant | output | N_MASTERS | One-hot bus ownership |
| owner | output | IDX_W | Index of the current owner |
| ev_grant_change | output | 1 | Event: ownership changed |
| ev_split_start | output | 1 | Event: a split was taken |
| ev_split_done | output | 1 | Event: a split was released |

## Verification
The checker watches several properties in every cycle. It checks that the grant is one-hot and matches the owner index, that ownership holds while `ready` is low, and that the arbiter parks on the default master when nothing is requested. It also checks that a split response sets the owner's mask bit, that any completion bit leaves the mask clear, and that each event strobe follows its cause. The rotation order can only be shown by the bench's scenarios. So can skipping a masked master, the absence of priority for a master just released, and the clearing of state by a reset issued mid-run. The bench runs a directed sequence with known owner values and then a long pseudo-random sweep against an arithmetic model.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  // Event strobes toward a performance counter block
  typedef struct packed {
    logic grant_chg;
    logic split_start;
    logic split_done;
  } arb_events_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rr_arb_rst_sync.sv
module rr_arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/rr_arb_picker.sv
// Rotating-priority search: first set bit of elig at or above base, wrapping.
module rr_arb_picker #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] win
);

  always_comb begin
    int idx;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N; k++) begin
      idx = int'(base) + k;
      if (idx >= N) idx = idx - N;
      if (!found && elig[idx]) begin
        found = 1'b1;
        win   = idx[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/rr_arb_split_mask.sv
// Per-master split mask; completion overrides a same-cycle set.
module rr_arb_split_mask #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [N-1:0]  done,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  mask_d,
  output logic          released
);

  logic [N-1:0] set_vec;
  logic [N-1:0] pending;

  always_comb begin
    set_vec = '0;
    if (set_en) set_vec[set_idx] = 1'b1;
    pending  = mask_q | set_vec;
    mask_d   = pending & ~done;
    released = |(pending & done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

endmodule

// File: rtl/rr_split_arbiter.sv
module rr_split_arbiter #(
  parameter int N_MASTERS      = 4,
  parameter int DEFAULT_MASTER = 0,
  localparam int IDX_W         = rr_arb_pkg::idx_width(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 ready,
  input  logic                 split_resp,
  input  logic [N_MASTERS-1:0] split_done,
  output logic [N_MASTERS-1:0] grant,
  output logic [IDX_W-1:0]     owner,
  output logic                 ev_grant_change,
  output logic                 ev_split_start,
  output logic                 ev_split_done
);
  import rr_arb_pkg::*;

  localparam logic [IDX_W-1:0] DEF_IDX  = IDX_W'(DEFAULT_MASTER);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_MASTERS - 1);

  logic                 rst_sync_n;
  logic [IDX_W-1:0]     owner_q, owner_d;
  logic [IDX_W-1:0]     ptr_q, ptr_d;
  logic [N_MASTERS-1:0] split_mask, mask_next;
  logic [N_MASTERS-1:0] eligible;
  logic                 split_fire;
  logic                 split_released;
  logic                 pick_found;
  logic [IDX_W-1:0]     pick_win;
  arb_events_t          ev_d, ev_q;

  rr_arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign split_fire = ready & split_resp;

  rr_arb_split_mask #(.N(N_MASTERS), .IW(IDX_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_en   (split_fire),
    .set_idx  (owner_q),
    .done     (split_done),
    .mask_q   (split_mask),
    .mask_d   (mask_next),
    .released (split_released)
  );

  assign eligible = req & ~mask_next;

  rr_arb_picker #(.N(N_MASTERS), .IW(IDX_W)) u_pick (
    .elig  (eligible),
    .base  (ptr_q),
    .found (pick_found),
    .win   (pick_win)
  );

  // Next-state logic
  always_comb begin
    owner_d = owner_q;
    ptr_d   = ptr_q;
    if (ready) begin
      if (pick_found) begin
        owner_d = pick_win;
        ptr_d   = (pick_win == LAST_IDX) ? '0 : pick_win + 1'b1;
      end else begin
        owner_d = DEF_IDX;
      end
    end
    ev_d.grant_chg   = ready && (owner_d != owner_q);
    ev_d.split_start = split_fire;
    ev_d.split_done  = split_released;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      owner_q <= DEF_IDX;
      ptr_q   <= '0;
      ev_q    <= '0;
    end else begin
      if (ready) begin
        owner_q <= owner_d;
        ptr_q   <= ptr_d;
      end
      ev_q <= ev_d;
    end
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
    assign grant[g] = (owner_q == IDX_W'(g));
  end

  assign owner           = owner_q;
  assign ev_grant_change = ev_q.grant_chg;
  assign ev_split_start  = ev_q.split_start;
  assign ev_split_done   = ev_q.split_done;

endmodule

// File: rtl/rr_split_arbiter_chk.sv
module rr_split_arbiter_chk #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int DM = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic          ready,
  input logic          split_resp,
  input logic [N-1:0]  split_done,
  input logic [N-1:0]  grant,
  input logic [IW-1:0] owner,
  input logic [N-1:0]  mask,
  input logic          ev_grant_change,
  input logic          ev_split_start
);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1);

  // R2
  grant_owner_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[owner] == 1'b1);

  // R3
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(owner));

  // R5
  park_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req == '0) |=> owner == IW'(DM));

  // R6
  split_sets_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && split_resp && !split_done[owner]) |=> mask[$past(owner)]);

  // R8
  done_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split_done != '0) |=> (mask & $past(split_done)) == '0);

  // R9
  split_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && split_resp) |=> ev_split_start);

  // R9
  no_change_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !ev_grant_change);

endmodule

bind rr_split_arbiter rr_split_arbiter_chk #(
  .N(N_MASTERS), .IW(IDX_W), .DM(DEFAULT_MASTER)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .req             (req),
  .ready           (ready),
  .split_resp      (split_resp),
  .split_done      (split_done),
  .grant           (grant),
  .owner           (owner),
  .mask            (split_mask),
  .ev_grant_change (ev_grant_change),
  .ev_split_start  (ev_split_start)
);

// File: tb/rr_split_arbiter_test.sv
module rr_split_arbiter_test;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         ready;
  logic         split_resp;
  logic [N-1:0] split_done;
  logic [N-1:0] grant;
  logic [1:0]   owner;
  logic         ev_grant_change, ev_split_start, ev_split_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Model state
  int       m_own, m_ptr;
  logic [N-1:0] m_mask;
  logic     me_g, me_s, me_d;

  always #10 clk = ~clk; // 50 MHz

  rr_split_arbiter #(.N_MASTERS(N), .DEFAULT_MASTER(0)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready),
    .split_resp(split_resp), .split_done(split_done),
    .grant(grant), .owner(owner),
    .ev_grant_change(ev_grant_change), .ev_split_start(ev_split_start),
    .ev_split_done(ev_split_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_own = 0; m_ptr = 0; m_mask = '0;
    me_g = 0; me_s = 0; me_d = 0;
  endtask

  task automatic model_step(input logic [N-1:0] rq, input logic rd,
                            input logic sp, input logic [N-1:0] dn);
    logic [N-1:0] setv, nm, el;
    int prev;
    bit got;
    setv = (rd && sp) ? (N'(1) << m_own) : '0;
    nm   = (m_mask | setv) & ~dn;
    el   = rq & ~nm;
    prev = m_own;
    me_s = rd && sp;
    me_d = |(dn & (m_mask | setv));
    if (rd) begin
      got = 0;
      for (int k = 0; k < N; k++) begin
        int ix;
        ix = (m_ptr + k) % N;
        if (!got && el[ix]) begin
          got = 1; m_own = ix; m_ptr = (ix + 1) % N;
        end
      end
      if (!got) m_own = 0;
    end
    me_g   = (m_own != prev);
    m_mask = nm;
  endtask

  // Apply inputs at a falling edge, clock once, compare at the next falling edge.
  task automatic cyc(input logic [N-1:0] rq, input logic rd, input logic sp,
                     input logic [N-1:0] dn, input int exp_own, input string tag);
    req = rq; ready = rd; split_resp = sp; split_done = dn;
    model_step(rq, rd, sp, dn);
    @(posedge clk);
    @(negedge clk);
    check("R3 R4 owner vs model", int'(owner), m_own);
    check("R2 grant one-hot", int'(grant), 1 << m_own);
    check("R9 grant-change event", int'(ev_grant_change), int'(me_g));
    check("R9 split-start event", int'(ev_split_start), int'(me_s));
    check("R9 split-done event", int'(ev_split_done), int'(me_d));
    if (exp_own >= 0) check(tag, int'(owner), exp_own);
  endtask

  task automatic do_reset();
    req = '0; ready = 1'b0; split_resp = 1'b0; split_done = '0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // R1: reset state
    check("R1 reset owner", int'(owner), 0);
    check("R1 reset grant", int'(grant), 1);
    check("R1 reset events", int'({ev_grant_change, ev_split_start, ev_split_done}), 0);

    // R4: all requesting, rotation from master 0
    for (int i = 0; i < 6; i++) cyc(4'b1111, 1, 0, 4'b0000, i % 4, "R4 rotation");

    do_reset();
    cyc(4'b0010, 1, 0, 4'b0000, 1, "R4 single requester");
    // R6: split on owner 1; it is skipped
    cyc(4'b1111, 1, 1, 4'b0000, 2, "R6 split owner skipped");
    cyc(4'b1111, 1, 0, 4'b0000, 3, "R6 rotation continues");
    cyc(4'b1111, 1, 0, 4'b0000, 0, "R6 rotation continues");
    cyc(4'b1111, 1, 0, 4'b0000, 2, "R6 masked master passed over");
    // R7: completion; master 1 waits its turn
    cyc(4'b1111, 1, 0, 4'b0010, 3, "R7 no priority on release");
    cyc(4'b1111, 1, 0, 4'b0000, 0, "R7 normal order");
    cyc(4'b1111, 1, 0, 4'b0000, 1, "R7 released master wins in turn");
    // R8: split and completion together on owner 1
    cyc(4'b1111, 1, 1, 4'b0010, 2, "R8 same-cycle split and done");
    cyc(4'b0010, 1, 0, 4'b0000, 1, "R8 mask left clear");
    // R3: ready low holds owner
    cyc(4'b1101, 0, 0, 4'b0000, 1, "R3 hold while busy");
    cyc(4'b0100, 0, 1, 4'b0000, 1, "R3 hold while busy");
    // R5: park and pointer kept
    cyc(4'b0000, 1, 0, 4'b0000, 0, "R5 park on default");
    cyc(4'b1111, 1, 0, 4'b0000, 2, "R5 pointer unchanged by park");
    // Set a mask on master 3, then reset mid-run
    cyc(4'b1111, 1, 0, 4'b0000, 3, "R4 rotation");
    cyc(4'b1111, 1, 1, 4'b0000, 0, "R6 split owner skipped");
    rst_n = 1'b0;
    #1;
    check("R1 async reset owner", int'(owner), 0);
    do_reset();
    cyc(4'b1000, 1, 0, 4'b0000, 3, "R1 mask cleared by reset");
    do_reset();
    cyc(4'b1111, 1, 0, 4'b0000, 0, "R1 pointer starts at master 0");

    // Pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] dn;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dn = '0;
      for (int b = 0; b < N; b++) dn[b] = (lfsr[(b*3+5)%16] & lfsr[(b*5+2)%16] & lfsr[(b+9)%16]);
      cyc(lfsr[3:0], lfsr[5] | lfsr[6], lfsr[7] & lfsr[8] & lfsr[9], dn, -1, "");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule